// File: doc/BRIEF.md
# ADC Result Register Read Interface

This block sits between the conversion sequencer of an analog-to-digital converter and the processor bus. It keeps the most recent completed result in a holding register. The result is loaded only when the sequencer pulses its completion strobe. The processor sees the result through two byte-wide registers, a low one and a high one, selected by `addr_hi`. The high register also carries a writable bit that picks between 10-bit and 8-bit conversion.

In 10-bit mode, software can fetch the full value by reading the high register first and then the low one. It can also fetch an 8-bit approximation by reading the low register alone. An internal alignment flag does this job:

- A read of the high register switches the low register to show the least significant eight result bits.
- A conversion start or a read of the low register switches it back to the most significant eight bits.
- Each read returns the value selected before its own update.

In 8-bit mode the whole result lives in the low register.

Read data is registered. It appears on `rd_data` one cycle after the read strobe, marked by `rd_valid`, and holds until the next read.

Top module: `adc_result_if`

## Requirements
- R1: After reset the held result is 0, the mode bit is 0 (10-bit), the alignment is MSB, `rd_data` is 0 and `rd_valid` is 0.
- R2: The held result changes only in a cycle where `res_valid` is 1. Reads at any other time return the previously completed result.
- R3: A write (`wr_en`=1) with `addr_hi`=1 sets the mode bit from `wr_data[7]` (0 = 10-bit, 1 = 8-bit). Other write bits and writes with `addr_hi`=0 change neither the mode bit nor the result.
- R4: A read with `addr_hi`=1 returns the mode bit in bit 7, zeros in bits 6..2 and result bits 9..8 in bits 1..0.
- R5: In 10-bit mode, a read with `addr_hi`=0 returns result bits 9..2 when the last event among reset, conversion start and register read was a reset, a start or a low read.
- R6: In 10-bit mode, a read with `addr_hi`=0 returns result bits 7..0 when the last such event was a high read.
- R7: While the mode bit is 1, a completion strobe stores `{2'b00, res_data[7:0]}`, and a low read returns result bits 7..0 whatever the alignment.
- R8: When `conv_start` and a high read fall in the same cycle, the start wins and the alignment becomes MSB. The read still returns the high register.
- R9: A read in the same cycle as `res_valid` returns the result held before that strobe.
- R10: `rd_data` is updated and `rd_valid` pulses exactly one cycle after a cycle with `rd_en`=1. Otherwise `rd_data` holds its value and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Conversion start pulse from the sequencer |
| res_valid | input | 1 | Completion strobe; loads `res_data` |
| res_data | input | 10 | Completed conversion result |
| addr_hi | input | 1 | Register select: 0 low byte, 1 high byte |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| mode_8bit | output | 1 | Conversion mode bit to the sequencer |

## Verification
Two pairs of events can land in one cycle. A bus read can coincide with the completion strobe. A high read can coincide with a conversion start. The bench drives each pair in a single cycle. It then judges the first case by the byte returned, which must be the old result, and the second case by the next low read, which must be MSB-aligned. A scoreboard queue holds every expected read byte in issue order, so a read that picks up the new result or the wrong alignment shows up as a mismatch on that exact read.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
    localparam int RES_W  = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = RES_W - BYTE_W;
    localparam int PAD_W  = BYTE_W - 1 - HI_W;

    typedef logic [RES_W-1:0]  result_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        result_t res;
        logic    mode;
    } hold_state_t;

    typedef struct packed {
        byte_t data;
        logic  vld;
    } rd_state_t;
endpackage

// File: rtl/adc_res_hold.sv
module adc_res_hold
    import adc_result_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    res_valid,
    input  result_t res_data,
    input  logic    mode_wr,
    input  logic    mode_wdata,
    output result_t res_q,
    output logic    mode_q
);
    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (res_valid) begin
            if (st_q.mode)
                st_d.res = {{HI_W{1'b0}}, res_data[BYTE_W-1:0]};
            else
                st_d.res = res_data;
        end
        if (mode_wr)
            st_d.mode = mode_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_q  = st_q.res;
    assign mode_q = st_q.mode;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(res_q)); // R2
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_q)); // R3
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mode_q) |=> (res_q[RES_W-1:BYTE_W] == '0)); // R7
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start,
    input  logic rd_en,
    input  logic addr_hi,
    output logic lsb_sel_q
);
    logic lsb_sel_d;

    always_comb begin
        lsb_sel_d = lsb_sel_q;
        if (conv_start)
            lsb_sel_d = 1'b0;
        else if (rd_en)
            lsb_sel_d = addr_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lsb_sel_q <= 1'b0;
        else        lsb_sel_q <= lsb_sel_d;
    end

    AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !lsb_sel_q); // R8
    AST_LO_RD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_hi) |=> !lsb_sel_q); // R5
    AST_HI_RD_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_hi && !conv_start) |=> lsb_sel_q); // R6
endmodule

// File: rtl/adc_res_rdmux.sv
module adc_res_rdmux
    import adc_result_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rd_en,
    input  logic    addr_hi,
    input  result_t res_q,
    input  logic    mode_q,
    input  logic    lsb_sel_q,
    output byte_t   rd_data,
    output logic    rd_valid
);
    rd_state_t st_d, st_q;
    byte_t     lo_view, hi_view;

    always_comb begin
        hi_view = {mode_q, {PAD_W{1'b0}}, res_q[RES_W-1:BYTE_W]};
        if (mode_q || lsb_sel_q)
            lo_view = res_q[BYTE_W-1:0];
        else
            lo_view = res_q[RES_W-1:HI_W];

        st_d     = st_q;
        st_d.vld = rd_en;
        if (rd_en)
            st_d.data = addr_hi ? hi_view : lo_view;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data;
    assign rd_valid = st_q.vld;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && !rd_valid)); // R10
    AST_HI_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_hi) |=> (rd_data[BYTE_W-2:HI_W] == '0)); // R4
    AST_HI_MODE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_hi) |=> (rd_data[BYTE_W-1] == $past(mode_q))); // R4
endmodule

// File: rtl/adc_result_if.sv
module adc_result_if
    import adc_result_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic              res_valid,
    input  logic [RES_W-1:0]  res_data,
    input  logic              addr_hi,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              mode_8bit
);
    result_t res_q;
    logic    mode_q;
    logic    lsb_sel_q;
    logic    mode_wr;
    logic    unused_wr_bits;

    assign mode_wr        = wr_en && addr_hi;
    assign unused_wr_bits = ^wr_data[BYTE_W-2:0];

    adc_res_hold i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .mode_wr    (mode_wr),
        .mode_wdata (wr_data[BYTE_W-1]),
        .res_q      (res_q),
        .mode_q     (mode_q)
    );

    adc_res_align i_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .rd_en      (rd_en),
        .addr_hi    (addr_hi),
        .lsb_sel_q  (lsb_sel_q)
    );

    adc_res_rdmux i_rdmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .addr_hi    (addr_hi),
        .res_q      (res_q),
        .mode_q     (mode_q),
        .lsb_sel_q  (lsb_sel_q),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    assign mode_8bit = mode_q;
endmodule

// File: tb/test_adc_result_if.sv
module test_adc_result_if;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_start = 1'b0;
    logic       res_valid = 1'b0;
    logic [9:0] res_data = '0;
    logic       addr_hi = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       mode_8bit;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    adc_result_if i_adc_result_if (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .res_valid(res_valid),
        .res_data(res_data), .addr_hi(addr_hi), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .mode_8bit(mode_8bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one bus cycle; inputs set at the falling edge
    task automatic cyc(input logic st, input logic vld, input logic [9:0] d,
                       input logic rd, input logic hi, input logic wr,
                       input logic [7:0] wd);
        @(negedge clk);
        conv_start = st; res_valid = vld; res_data = d;
        rd_en = rd; addr_hi = hi; wr_en = wr; wr_data = wd;
    endtask

    task automatic idle();
        cyc(0, 0, '0, 0, 0, 0, '0);
    endtask

    task automatic rd(input logic hi, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cyc(0, 0, '0, 1, hi, 0, '0);
    endtask

    // monitor: pop one expectation per returned byte
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R10: unexpected read data %02h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_data reset", rd_data, 8'h00);
        check("R1 rd_valid reset", {7'b0, rd_valid}, 8'h00);
        check("R1 mode reset", {7'b0, mode_8bit}, 8'h00);
        rst_n = 1'b1;
        rd(1, 8'h00, "R1 high after reset");
        idle();
        rd(0, 8'h00, "R1 low after reset");
        // load 0x2D6
        cyc(0, 1, 10'h2D6, 0, 0, 0, '0);
        rd(0, 8'hB5, "R5 low MSB-aligned");
        rd(1, 8'h02, "R4 high layout");
        rd(0, 8'hD6, "R6 low after high read");
        rd(0, 8'hB5, "R5 low after low read");
        rd(1, 8'h02, "R4 high again");
        cyc(1, 0, '0, 0, 0, 0, '0);
        rd(0, 8'hB5, "R5 low after start");
        // R2: idle cycles with data on bus but no strobe
        cyc(0, 0, 10'h3FF, 0, 0, 0, '0);
        rd(0, 8'hB5, "R2 no strobe keeps result");
        // R9: read coincides with strobe
        exp_q.push_back(8'hB5); tag_q.push_back("R9 read with strobe returns old");
        cyc(0, 1, 10'h1C3, 1, 0, 0, '0);
        rd(0, 8'h70, "R9 new result after strobe");
        // R8: high read with start in same cycle
        exp_q.push_back(8'h01); tag_q.push_back("R8 high read with start");
        cyc(1, 0, '0, 1, 1, 0, '0);
        rd(0, 8'h70, "R8 start wins, MSB-aligned");
        // R3: mode writes
        cyc(0, 0, '0, 0, 1, 1, 8'hFF);
        rd(1, 8'h81, "R3 mode set via bit 7");
        cyc(0, 0, '0, 0, 0, 1, 8'h00);
        rd(1, 8'h81, "R3 low-address write ignored");
        cyc(0, 0, '0, 0, 1, 1, 8'h7F);
        rd(1, 8'h01, "R3 mode cleared, other bits ignored");
        cyc(0, 0, '0, 0, 1, 1, 8'h80);
        idle();
        check("R3 mode output", {7'b0, mode_8bit}, 8'h01);
        // R7: 8-bit mode
        cyc(0, 1, 10'h3A5, 0, 0, 0, '0);
        rd(0, 8'hA5, "R7 low in 8-bit mode");
        rd(1, 8'h80, "R7 upper bits cleared");
        rd(0, 8'hA5, "R7 low after high read");
        // R10: data held while idle
        idle(); idle(); idle();
        check("R10 data held", rd_data, 8'hA5);
        check("R10 no valid when idle", {7'b0, rd_valid}, 8'h00);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10: missing reads actual %0d expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule